// File: doc/BRIEF.md
# Per-Instruction Prefetch Degree Predictor

This block learns, for each load or fetch instruction, how many sequential cache lines are worth fetching when that instruction misses in the L1 cache. It keeps a table of two-bit saturating counters. A hash of the instruction address selects one counter. When a miss is accepted, the block reads that counter and sends out a burst of prefetch line addresses just past the missed line. The burst holds zero, one, three or seven lines, depending on the counter value.

A separate structure watches miss addresses and raises increment requests that name a counter index. The block applies each one by strengthening that counter until it saturates. Counters also have to weaken again over time. To do this, the block counts misses that actually prefetch, and weakens the counter of the miss that reaches a threshold. A small LFSR moves that threshold around, so the decrements do not fall into step with loop cadences.

The table is read and changed only on accepted misses and on increment requests. Prefetch addresses leave through a valid/ready handshake, one per cycle. The block accepts no new miss until the current burst has drained.

Top module: `pf_degree_predictor`

## Requirements
- R1: After reset, every counter is 0, `miss_ready` is 1 and `pf_valid` is 0.
- R2: A miss on line N whose counter holds 0, 1, 2 or 3 issues 0, 1, 3 or 7 prefetch lines. These are N+1, N+2, … in ascending order, computed modulo 2^LINE_W.
- R3: The counter index is `miss_pc[ALIGN_W+IDX_W-1:ALIGN_W]`, with defaults ALIGN_W=2 and IDX_W=8. Other PC bits do not affect the index.
- R4: An increment request (`inc_valid` with `inc_idx`) raises the named counter by one and saturates at 3.
- R5: `pf_line` holds steady while `pf_valid` is high and `pf_ready` is low. Each handshake moves to the next line.
- R6: `miss_ready` is high exactly when no burst is in flight. The first line of a burst is valid in the cycle after the miss is accepted. A miss with counter 0 leaves `miss_ready` high.
- R7: Each accepted miss with a nonzero counter adds one to a miss count. When the count reaches 16 + S, that miss's counter drops by one after its burst has used the old value. The count then clears and S advances. S is a 5-bit LFSR that resets to 1 and steps as S <= {S[3:0], S[4]^S[2]}.
- R8: Misses whose counter is 0 do not change the miss count or the LFSR.
- R9: If an increment and a decrement target the same counter in the same cycle, that counter is unchanged.
- R10: A miss accepted in the same cycle as an increment to its own counter uses the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | An L1 miss is presented |
| miss_ready | output | 1 | Block can accept a miss (no burst in flight) |
| miss_pc | input | PC_W | Instruction address of the missing access |
| miss_line | input | LINE_W | Line address that missed |
| inc_valid | input | 1 | Increment request |
| inc_idx | input | IDX_W | Counter index to increment |
| pf_valid | output | 1 | Prefetch line address valid |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_line | output | LINE_W | Prefetch line address |

## Verification
The counters can only be seen through the length of the next burst from the same index. A wrong counter value therefore shows up at the next miss on that instruction, as a burst that is too short or too long. A decay counter or LFSR that has drifted out of step moves the decrement to a different miss. That error becomes visible one miss later on the same index, so the bench follows the decay state through long mixed runs of misses. A wrong burst sequencer shows up right away: a repeated or skipped `pf_line`, or `miss_ready` rising too early.

// File: rtl/pfdp_pkg.sv
package pfdp_pkg;
  typedef enum logic [1:0] {
    DEG_NONE  = 2'd0,
    DEG_ONE   = 2'd1,
    DEG_THREE = 2'd2,
    DEG_SEVEN = 2'd3
  } deg_e;

  // number of lines in a burst for a given strength: 2^deg - 1
  function automatic logic [2:0] burst_len(input deg_e d);
    case (d)
      DEG_ONE:   burst_len = 3'd1;
      DEG_THREE: burst_len = 3'd3;
      DEG_SEVEN: burst_len = 3'd7;
      default:   burst_len = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pfdp_table.sv
module pfdp_table #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_deg,
  input  logic             inc_en,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic             dec_en,
  input  logic [IDX_W-1:0] dec_idx
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [2*ENTRIES-1:0] flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [1:0] q, d;
    logic       up, dn, en;

    always_comb begin
      up = inc_en && (inc_idx == IDX_W'(i));
      dn = dec_en && (dec_idx == IDX_W'(i));
      en = up ^ dn;
      d  = q;
      if (up && (q != 2'd3)) d = q + 2'd1;
      if (dn && (q != 2'd0)) d = q - 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 2'd0;
      else if (en) q <= d;
    end

    assign flat[2*i +: 2] = q;
  end

  assign rd_deg = flat[2*rd_idx +: 2];
endmodule

// File: rtl/pfdp_decay.sv
module pfdp_decay #(
  parameter int          LFSR_W   = 5,
  parameter logic [4:0]  TAPS     = 5'b10100,
  parameter int          THR_BASE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  output logic fire
);
  localparam int CNT_W = $clog2(THR_BASE + (1 << LFSR_W));

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc, thr;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              fb;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    thr     = CNT_W'(THR_BASE) + CNT_W'(lfsr_q);
    fire    = ev && (cnt_inc == thr);
    fb      = ^(lfsr_q & TAPS[LFSR_W-1:0]);
    lfsr_d  = fire ? {lfsr_q[LFSR_W-2:0], fb} : lfsr_q;
    cnt_d   = fire ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_W'(1);
    end else if (ev) begin
      cnt_q  <= cnt_d;
      lfsr_q <= lfsr_d;
    end
  end
endmodule

// File: rtl/pfdp_issue.sv
module pfdp_issue #(
  parameter int LINE_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] base_line,
  input  logic [2:0]        nlines,
  output logic              busy,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);
  logic              busy_q, busy_d;
  logic [LINE_W-1:0] cur_q, cur_d;
  logic [2:0]        rem_q, rem_d;
  logic              load, step;

  always_comb begin
    load   = start && !busy_q && (nlines != 3'd0);
    step   = busy_q && pf_ready;
    busy_d = busy_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    if (load) begin
      busy_d = 1'b1;
      cur_d  = base_line + LINE_W'(1);
      rem_d  = nlines;
    end else if (step) begin
      cur_d  = cur_q + LINE_W'(1);
      rem_d  = rem_q - 3'd1;
      busy_d = (rem_q != 3'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      rem_q  <= '0;
    end else if (load || step) begin
      busy_q <= busy_d;
      cur_q  <= cur_d;
      rem_q  <= rem_d;
    end
  end

  assign busy     = busy_q;
  assign pf_valid = busy_q;
  assign pf_line  = cur_q;
endmodule

// File: rtl/pf_degree_predictor.sv
module pf_degree_predictor #(
  parameter int PC_W     = 32,
  parameter int ALIGN_W  = 2,
  parameter int IDX_W    = 8,
  parameter int LINE_W   = 30,
  parameter int LFSR_W   = 5,
  parameter int THR_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              inc_valid,
  input  logic [IDX_W-1:0]  inc_idx,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);
  import pfdp_pkg::*;

  localparam int IDX_LO = ALIGN_W;
  localparam int IDX_HI = ALIGN_W + IDX_W - 1;

  logic [IDX_W-1:0] idx;
  logic [1:0]       deg;
  logic             accept, busy, fire, pf_miss;
  logic             pc_unused;

  assign idx       = miss_pc[IDX_HI:IDX_LO];
  assign pc_unused = ^{miss_pc[PC_W-1:IDX_HI+1], miss_pc[IDX_LO-1:0]};
  assign miss_ready = !busy;
  assign accept    = miss_valid && miss_ready;
  assign pf_miss   = accept && (deg != 2'd0);

  pfdp_table #(.IDX_W(IDX_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx),
    .rd_deg  (deg),
    .inc_en  (inc_valid),
    .inc_idx (inc_idx),
    .dec_en  (fire),
    .dec_idx (idx)
  );

  pfdp_decay #(.LFSR_W(LFSR_W), .THR_BASE(THR_BASE)) u_decay (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (pf_miss),
    .fire  (fire)
  );

  pfdp_issue #(.LINE_W(LINE_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .base_line (miss_line),
    .nlines    (burst_len(deg_e'(deg))),
    .busy      (busy),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_line   (pf_line)
  );
endmodule

// File: rtl/pfdp_check.sv
module pfdp_check #(
  parameter int LINE_W = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [LINE_W-1:0] pf_line
);
  logic [3:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hs_cnt <= '0;
    else if (miss_ready)            hs_cnt <= '0;
    else if (pf_valid && pf_ready)  hs_cnt <= hs_cnt + 4'd1;
  end

  p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_cnt <= 4'd7);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |=> (!pf_valid || (pf_line == $past(pf_line) + 1'b1)));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !miss_ready);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_valid |-> miss_ready);
endmodule

bind pf_degree_predictor pfdp_check #(.LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .miss_ready (miss_ready),
  .pf_valid   (pf_valid),
  .pf_ready   (pf_ready),
  .pf_line    (pf_line)
);

// File: tb/pf_degree_predictor_test.sv
`timescale 1ns/1ps
module pf_degree_predictor_test;
  localparam int LW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid, miss_ready;
  logic [31:0]   miss_pc;
  logic [LW-1:0] miss_line;
  logic          inc_valid;
  logic [7:0]    inc_idx;
  logic          pf_valid, pf_ready;
  logic [LW-1:0] pf_line;

  pf_degree_predictor uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_pc(miss_pc), .miss_line(miss_line), .inc_valid(inc_valid), .inc_idx(inc_idx),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [LW-1:0] exp_q[$];
  string         tag_q[$];

  // reference state
  logic [1:0] mtbl [256];
  int         bcnt;
  logic [4:0] blfsr;
  bit         bp_en;
  int         cyc;

  function automatic logic [4:0] lstep(input logic [4:0] s);
    return {s[3:0], s[4] ^ s[2]};
  endfunction

  function automatic int nlines(input logic [1:0] d);
    return (1 << d) - 1;
  endfunction

  function automatic bit dec_due(input logic [7:0] i);
    return (mtbl[i] != 2'd0) && (bcnt + 1 == 16 + int'(blfsr));
  endfunction

  // ready pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    pf_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected pf_line act=%h exp=none", pf_line);
      end else begin
        logic [LW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (pf_line !== e) begin
          bad++;
          $display("FAIL %s pf_line act=%h exp=%h", t, pf_line, e);
        end
      end
    end
  end

  task automatic do_inc(input logic [7:0] i);
    @(negedge clk);
    inc_valid = 1'b1;
    inc_idx   = i;
    @(negedge clk);
    inc_valid = 1'b0;
    if (mtbl[i] != 2'd3) mtbl[i] = mtbl[i] + 2'd1;
  endtask

  task automatic do_miss(input logic [31:0] pc, input logic [LW-1:0] line,
                         input bit with_inc, input logic [7:0] ii, input string tag);
    logic [7:0] i;
    logic [1:0] d;
    bit dec;
    int n;
    i = pc[9:2];
    d = mtbl[i];
    dec = 1'b0;
    n = nlines(d);
    for (int k = 1; k <= n; k++) begin
      exp_q.push_back(line + LW'(k));
      tag_q.push_back(tag);
    end
    if (d != 2'd0) begin
      if (bcnt + 1 == 16 + int'(blfsr)) begin
        dec = 1'b1; bcnt = 0; blfsr = lstep(blfsr);
      end else bcnt++;
    end
    if (with_inc && dec && ii == i) begin
      // both cancel
    end else begin
      if (dec && mtbl[i] != 2'd0) mtbl[i] = mtbl[i] - 2'd1;
      if (with_inc && mtbl[ii] != 2'd3) mtbl[ii] = mtbl[ii] + 2'd1;
    end
    do @(negedge clk); while (!miss_ready);
    miss_valid = 1'b1; miss_pc = pc; miss_line = line;
    inc_valid = with_inc; inc_idx = ii;
    @(negedge clk);
    miss_valid = 1'b0; inc_valid = 1'b0;
    for (int w = 0; w < 60; w++) begin
      if (miss_ready) break;
      @(negedge clk);
    end
    total++;
    if (exp_q.size() != 0 || !miss_ready) begin
      bad++;
      $display("FAIL %s burst end act=left%0d/ready%0b exp=left0/ready1", tag, exp_q.size(), miss_ready);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic chk(input bit c, input string msg, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", msg, act, exp);
    end
  endtask

  localparam logic [31:0] PA = 32'h0000_0040; // idx 0x10
  localparam logic [31:0] PB = 32'h0000_0080; // idx 0x20
  localparam logic [31:0] PC = 32'h0000_00C0; // idx 0x30

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mtbl[k] = 2'd0;
    bcnt = 0; blfsr = 5'd1; bp_en = 1'b0; cyc = 0;
    rst_n = 1'b0; miss_valid = 1'b0; miss_pc = '0; miss_line = '0;
    inc_valid = 1'b0; inc_idx = '0; pf_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(miss_ready == 1'b1, "R1 miss_ready in reset", miss_ready, 1);
    chk(pf_valid == 1'b0, "R1 pf_valid in reset", pf_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miss_ready == 1'b1 && pf_valid == 1'b0, "R1 idle after reset", pf_valid, 0);

    // R1/R6: cleared counters, zero-degree miss keeps ready
    do_miss(PA, 30'h100, 0, 0, "R1");
    do_miss(32'h0000_03FC, 30'h200, 0, 0, "R1");
    @(negedge clk);
    chk(miss_ready == 1'b1, "R6 ready after zero miss", miss_ready, 1);

    // R2/R4: each strength
    do_inc(8'h10);
    do_miss(PA, 30'h1000, 0, 0, "R2 deg1");
    do_inc(8'h10);
    do_miss(PA, 30'h2000, 0, 0, "R2 deg2");
    do_inc(8'h10);
    do_miss(PA, 30'h3000, 0, 0, "R2 deg3");
    do_inc(8'h10);
    do_miss(PA, 30'h3100, 0, 0, "R4 saturate");

    // R3: alias with other high/low PC bits
    do_miss(PA + 32'h0000_0400 + 32'h3, 30'h4000, 0, 0, "R3 alias");
    do_miss(PA + 32'h0000_0004, 30'h4100, 0, 0, "R3 neighbour");

    // R2 wrap of line address
    do_miss(PA, {LW{1'b1}} - LW'(2), 0, 0, "R2 wrap");

    // R5 backpressure
    bp_en = 1'b1;
    do_miss(PA, 30'h5000, 0, 0, "R5 backpressure");
    do_miss(PA, 30'h5100, 0, 0, "R5 backpressure");
    bp_en = 1'b0;

    // R6: check first line timing
    do begin @(negedge clk); end while (!miss_ready);
    miss_valid = 1'b1; miss_pc = PA; miss_line = 30'h6000;
    for (int k = 1; k <= nlines(mtbl[8'h10]); k++) begin
      exp_q.push_back(30'h6000 + LW'(k)); tag_q.push_back("R6 first line");
    end
    if (mtbl[8'h10] != 0) begin
      if (bcnt + 1 == 16 + int'(blfsr)) begin
        bcnt = 0; blfsr = lstep(blfsr); mtbl[8'h10] = mtbl[8'h10] - 2'd1;
      end else bcnt++;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    chk(pf_valid == 1'b1 && miss_ready == 1'b0, "R6 burst starts next cycle", pf_valid, 1);
    while (!miss_ready) @(negedge clk);
    chk(exp_q.size() == 0, "R6 burst drained", exp_q.size(), 0);

    // R8: many zero-degree misses must not advance decay
    for (int k = 0; k < 40; k++) do_miss(PB, 30'h7000 + LW'(k), 0, 0, "R8 zero miss");

    // R7: long run, restore strength when it drops
    for (int k = 0; k < 70; k++) begin
      if (mtbl[8'h10] < 2'd3) do_inc(8'h10);
      do_miss(PA, 30'h8000 + LW'(k * 16), 0, 0, "R7 decay");
      if (k % 5 == 0) do_miss(PB, 30'h9000, 0, 0, "R8 zero miss");
    end

    // R10: miss plus increment to own counter away from threshold
    do_inc(8'h30);
    while (bcnt + 1 == 16 + int'(blfsr)) do_miss(PA, 30'hA000, 0, 0, "R7 decay");
    do_miss(PC, 30'hB000, 1, 8'h30, "R10 old value");
    do_miss(PC, 30'hB100, 0, 0, "R10 new value");

    // R9: increment and decrement collide on same counter
    for (int k = 0; k < 60 && !dec_due(8'h30); k++) begin
      if (mtbl[8'h30] < 2'd2) do_inc(8'h30);
      do_miss(PC, 30'hC000, 0, 0, "R7 decay");
    end
    chk(dec_due(8'h30), "R9 setup reached threshold", 0, 1);
    do_miss(PC, 30'hD000, 1, 8'h30, "R9 collide");
    do_miss(PC, 30'hD100, 0, 0, "R9 unchanged");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule